// File: doc/BRIEF.md
# Adaptive Link Voltage Swing Controller

This block selects the signal swing level used by the drivers of an on-chip link. Three levels are available (low, medium, high) and the block presents the chosen one as a one-hot select word that the analog drivers and receiver level shifters decode. The drivers, the shifters and the error detectors are outside the block; it sees only their pass/fail and per-word error indications.

Operation has two phases. A calibration phase starts on request: the swing drops to the lowest level, a crosstalk self-test is launched, and each failing run moves the swing one level up and launches the test again, until a run passes or the highest level is in use. The block then enters a run-time phase. It splits time into windows of `N` cycles, counts transferred words and flagged words in each window, and at the end of every window steps the level down, up or not at all depending on where the error ratio falls relative to 5% and 15%. The ratio is judged with multiplications by small constants instead of a divider.

Top module: `swing_ctrl`

## Requirements
- R1: `swing_sel` always has exactly one bit set: bit 2 selects the high level, bit 1 the medium level, bit 0 the low level.
- R2: After a synchronous reset the block is idle with `swing_sel` = 3'b100, and `test_start`, `cal_done` and `window_close` are low.
- R3: A `cal_go` pulse while idle sets `swing_sel` to 3'b001 in the next cycle, and `test_start` is high for exactly that one cycle.
- R4: While a test runs the level is held; a `test_done` with `test_pass` low below the high level raises the level by one in the next cycle, together with a new one-cycle `test_start`.
- R5: A `test_done` with `test_pass` high, or any `test_done` at the high level, ends calibration: in the next cycle the run phase starts, the level is kept and `cal_done` is high for that single cycle.
- R6: In the run phase `window_close` is high in the last cycle of every `N`-cycle window, counting from the first run cycle; it is never high outside the run phase.
- R7: When the window's flagged words times 20 is below its words, the level drops by one in the cycle after `window_close`, staying at low if already there.
- R8: When the window's flagged words times 20 exceeds three times its words, the level rises by one in the cycle after `window_close`, staying at high if already there.
- R9: Otherwise, including both exact band edges and windows with no words, the level is unchanged; in the run phase the level never changes except in the cycle after `window_close`.
- R10: `word_err` counts only in cycles where `word_vld` is high, and both counts restart at every window.
- R11: `cal_go` has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_go | input | 1 | Request to start calibration (accepted when idle) |
| test_done | input | 1 | Self-test run has finished this cycle |
| test_pass | input | 1 | Self-test result, valid with `test_done` (1 = no errors) |
| word_vld | input | 1 | A data word crossed the link this cycle |
| word_err | input | 1 | That word was flagged as erroneous |
| test_start | output | 1 | One-cycle launch of a self-test run |
| cal_done | output | 1 | One-cycle pulse in the first run-phase cycle |
| window_close | output | 1 | Last cycle of a run-phase observation window |
| swing_sel | output | 3 | One-hot swing select (bit 2 high, bit 1 medium, bit 0 low) |

## Verification
The windowed decision is driven with error counts placed just inside, exactly on and just beyond each threshold (1 of 20 and 3 of 20 are the band edges, 4 of 20 and 0 of 19 fall outside), which separates a strict comparison from an inclusive one and shows whether the thresholds are scaled correctly. Windows with fewer words than cycles check that the ratio is taken over words, not cycles, and a window with errors flagged but no valid words shows that stray error pulses are ignored. Runs that push down at low and up at high confirm saturation, and two calibration sequences, one passing at medium and one failing at every level, tell apart the pass exit from the top-level exit.

// File: rtl/swing_pkg.sv
package swing_pkg;

    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_MED  = 2'd1,
        LV_HIGH = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LAUNCH = 2'd1,
        PH_WAIT   = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_DOWN = 2'd1,
        MV_UP   = 2'd2
    } move_e;

    localparam int unsigned SEL_W = 3;

    function automatic logic [SEL_W-1:0] level_to_sel(level_e lv);
        return SEL_W'(1) << lv;
    endfunction

endpackage

// File: rtl/swing_window.sv
module swing_window #(
    parameter int unsigned N  = 64,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          word_vld,
    input  logic          word_err,
    output logic          close,
    output logic [CW-1:0] words_tot,
    output logic [CW-1:0] errs_tot
);
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] cyc;
        logic [CW-1:0] words;
        logic [CW-1:0] errs;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        close     = run && (win_q.cyc == PW'(N - 1));
        words_tot = win_q.words + CW'(word_vld);
        errs_tot  = win_q.errs + CW'(word_vld & word_err);
        win_d     = win_q;
        if (!run || close) begin
            win_d = '0;
        end else begin
            win_d.cyc   = win_q.cyc + PW'(1);
            win_d.words = words_tot;
            win_d.errs  = errs_tot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    AST_CLOSE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        close |-> run); // R6

    AST_ERRS_LE_WORDS: assert property (@(posedge clk) disable iff (rst)
        errs_tot <= words_tot); // R10

    AST_WORDS_BOUND: assert property (@(posedge clk) disable iff (rst)
        words_tot <= CW'(N)); // R10

endmodule

// File: rtl/swing_judge.sv
module swing_judge
    import swing_pkg::*;
#(
    parameter int unsigned CW = 7
) (
    input  logic [CW-1:0] words,
    input  logic [CW-1:0] errs,
    output move_e         move
);
    localparam int unsigned MW = CW + 5;

    logic [MW-1:0] errs_x20;
    logic [MW-1:0] words_x3;

    always_comb begin
        errs_x20 = MW'({errs, 4'b0000}) + MW'({errs, 2'b00});
        words_x3 = MW'({words, 1'b0}) + MW'(words);
        if (words == '0)              move = MV_HOLD;
        else if (errs_x20 < MW'(words)) move = MV_DOWN;
        else if (errs_x20 > words_x3) move = MV_UP;
        else                          move = MV_HOLD;
    end

endmodule

// File: rtl/swing_ctrl.sv
module swing_ctrl
    import swing_pkg::*;
#(
    parameter int unsigned N = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_go,
    input  logic       test_done,
    input  logic       test_pass,
    input  logic       word_vld,
    input  logic       word_err,
    output logic       test_start,
    output logic       cal_done,
    output logic       window_close,
    output logic [2:0] swing_sel
);
    localparam int unsigned CW = $clog2(N + 1);

    typedef struct packed {
        phase_e phase;
        level_e level;
        logic   done;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          close;
    logic [CW-1:0] words_tot;
    logic [CW-1:0] errs_tot;
    move_e         move;

    swing_window #(.N(N), .CW(CW)) u_window (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl_q.phase == PH_RUN),
        .word_vld  (word_vld),
        .word_err  (word_err),
        .close     (close),
        .words_tot (words_tot),
        .errs_tot  (errs_tot)
    );

    swing_judge #(.CW(CW)) u_judge (
        .words (words_tot),
        .errs  (errs_tot),
        .move  (move)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (cal_go) begin
                    ctl_d.level = LV_LOW;
                    ctl_d.phase = PH_LAUNCH;
                end
            end
            PH_LAUNCH: ctl_d.phase = PH_WAIT;
            PH_WAIT: begin
                if (test_done) begin
                    if (test_pass || ctl_q.level == LV_HIGH) begin
                        ctl_d.phase = PH_RUN;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.level = level_e'(ctl_q.level + 2'd1);
                        ctl_d.phase = PH_LAUNCH;
                    end
                end
            end
            PH_RUN: begin
                if (close) begin
                    if (move == MV_UP && ctl_q.level != LV_HIGH)
                        ctl_d.level = level_e'(ctl_q.level + 2'd1);
                    else if (move == MV_DOWN && ctl_q.level != LV_LOW)
                        ctl_d.level = level_e'(ctl_q.level - 2'd1);
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{phase: PH_IDLE, level: LV_HIGH, done: 1'b0};
        else     ctl_q <= ctl_d;
    end

    assign swing_sel    = level_to_sel(ctl_q.level);
    assign test_start   = (ctl_q.phase == PH_LAUNCH);
    assign cal_done     = ctl_q.done;
    assign window_close = close;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(swing_sel) == 1); // R1

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        test_start |=> !test_start); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done); // R5

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_RUN && !close) |=> $stable(swing_sel)); // R9

    AST_NO_JUMP_UP: assert property (@(posedge clk) disable iff (rst)
        (close && swing_sel == 3'b001) |=> swing_sel != 3'b100); // R8

    AST_NO_JUMP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (close && swing_sel == 3'b100) |=> swing_sel != 3'b001); // R7

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == PH_WAIT && !test_done) |=> $stable(swing_sel)); // R4

endmodule

// File: tb/sim_swing_ctrl.sv
`timescale 1ns/1ps
module sim_swing_ctrl;
    localparam int N = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_go = 1'b0;
    logic       test_done = 1'b0;
    logic       test_pass = 1'b0;
    logic       word_vld = 1'b0;
    logic       word_err = 1'b0;
    logic       test_start, cal_done, window_close;
    logic [2:0] swing_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    swing_ctrl #(.N(N)) u0 (
        .clk(clk), .rst(rst), .cal_go(cal_go), .test_done(test_done),
        .test_pass(test_pass), .word_vld(word_vld), .word_err(word_err),
        .test_start(test_start), .cal_done(cal_done),
        .window_close(window_close), .swing_sel(swing_sel)
    );

    // words, flagged words, expected level after window (0 low, 1 med, 2 high)
    localparam int NV = 11;
    localparam int VEC [NV][3] = '{
        '{20,  0, 0},  // R7 below 5%: medium -> low
        '{20,  0, 0},  // R7 saturate at low
        '{20,  1, 0},  // R9 exactly 5%: hold
        '{20,  4, 1},  // R8 above 15%: up
        '{20,  3, 1},  // R9 exactly 15%: hold
        '{10,  2, 2},  // R8 ratio over words, not cycles
        '{20, 10, 2},  // R8 saturate at high
        '{ 0,  5, 2},  // R10 errors without valid words ignored, R9 empty window
        '{19,  0, 1},  // R7 down
        '{20,  1, 1},  // R10 counts restarted: 5% holds
        '{15,  0, 0}   // R7 down
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sel_of(input int lv);
        return 1 << lv;
    endfunction

    // Entered at the negedge of window cycle 0; leaves at the negedge of the next window's cycle 0.
    task automatic run_window(input int w, input int e, input int exp_lv, input bit poke, input string tag);
        int start_sel;
        start_sel = swing_sel;
        for (int i = 0; i < N; i++) begin
            word_vld = (i < w);
            word_err = (i < e);
            cal_go   = poke && (i == 0);
            if (i == 0)
                chk(window_close == 1'b0, "R6 first cycle", window_close, 0);
            if (i == N - 1)
                chk(window_close == 1'b1, "R6 last cycle", window_close, 1);
            if (poke && i == 1) begin
                chk(test_start == 1'b0, "R11 no test launch", test_start, 0);
                chk(swing_sel == start_sel[2:0], "R11 level kept", swing_sel, start_sel);
            end
            @(negedge clk);
        end
        word_vld = 1'b0;
        word_err = 1'b0;
        cal_go   = 1'b0;
        chk(swing_sel == sel_of(exp_lv), tag, swing_sel, sel_of(exp_lv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk(swing_sel == 3'b100, "R2 sel", swing_sel, 4);
        chk(test_start == 1'b0, "R2 test_start", test_start, 0);
        chk(cal_done == 1'b0, "R2 cal_done", cal_done, 0);
        chk(window_close == 1'b0, "R2 window_close", window_close, 0);
        // R11/R2: idle without request stays put
        repeat (3) @(negedge clk);
        chk(swing_sel == 3'b100 && test_start == 1'b0, "R2 idle hold", swing_sel, 4);

        // First calibration: fail at low, pass at medium
        cal_go = 1'b1;
        @(negedge clk);
        cal_go = 1'b0;
        chk(swing_sel == 3'b001, "R3 start at low", swing_sel, 1);
        chk(test_start == 1'b1, "R3 test_start", test_start, 1);
        @(negedge clk);
        chk(test_start == 1'b0, "R3 one-cycle start", test_start, 0);
        repeat (4) @(negedge clk);
        chk(swing_sel == 3'b001 && window_close == 1'b0, "R4 held while testing", swing_sel, 1);
        test_done = 1'b1; test_pass = 1'b0;
        @(negedge clk);
        test_done = 1'b0;
        chk(swing_sel == 3'b010, "R4 raise after fail", swing_sel, 2);
        chk(test_start == 1'b1, "R4 relaunch", test_start, 1);
        @(negedge clk);
        test_done = 1'b1; test_pass = 1'b1;
        @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0;
        chk(cal_done == 1'b1, "R5 cal_done", cal_done, 1);
        chk(swing_sel == 3'b010, "R5 level kept", swing_sel, 2);

        // Run-time windows from the table
        for (int v = 0; v < NV; v++)
            run_window(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, "R7/R8/R9 window level");
        chk(cal_done == 1'b0, "R5 cal_done single", cal_done, 0);

        // Reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(swing_sel == 3'b100 && window_close == 1'b0, "R2 reset in run", swing_sel, 4);

        // Second calibration: fail at every level, exit at high
        cal_go = 1'b1;
        @(negedge clk);
        cal_go = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(swing_sel == sel_of(k), "R4 climb level", swing_sel, sel_of(k));
            @(negedge clk);
            test_done = 1'b1; test_pass = 1'b0;
            @(negedge clk);
            test_done = 1'b0;
        end
        chk(cal_done == 1'b1, "R5 exit at high", cal_done, 1);
        chk(swing_sel == 3'b100, "R5 high kept", swing_sel, 4);
        chk(test_start == 1'b0, "R5 no relaunch", test_start, 0);
        run_window(20, 20, 2, 1'b1, "R11 R8 saturate with ignored request");
        run_window(20, 0, 1, 1'b0, "R7 down from high");

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule